// File: doc/BRIEF.md
# Bucketed MAC Table Lookup Engine

This engine resolves a key made of a 48-bit MAC address and an 8-bit filtering database identifier (FID) against a hashed forwarding table. The caller supplies the key together with a precomputed hash. The engine then reads the four-entry bucket that the hash selects, one entry per clock cycle, through a synchronous-read memory port. It stops as soon as the outcome is known.

A bucket that has run out of room can pass the search on to a small overflow CAM. It does this through a flag and a start pointer held in one of its entries. The engine then walks the CAM through a second synchronous-read port until the search resolves.

Both memories hold two banks. The bank is chosen by a configuration input that is sampled once per lookup. Only one lookup is in flight at a time. The result is a hit/miss flag plus the full matched entry, and it is held on a valid/ready handshake until the consumer takes it.

Top module: `mac_bucket_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and neither memory read enable is active while no request is offered.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In that same cycle the engine reads table address {bank, hash, 2'b00}, with the bank in the top bit(s) and the entry index in the two low bits.
- R3: An entry matches only if it is valid and both its MAC and its FID equal the key. A hit returns rsp_hit=1 and the entry unchanged in rsp_entry. The entry layout is the packed package struct, most significant first: valid, end-of-bucket, bpdu, mac[48], fid[8], source mask[16], destination mask[16], three drop flags, source priority[3] with has/override bits, destination priority[3] with has/override bits, cam-continue, cam pointer[5].
- R4: Bucket entries are read in index order 0 to 3, one read per cycle. The search stops at the first match, and no further reads are issued.
- R5: A non-matching entry that is not valid ends the search with a miss.
- R6: A valid, non-matching entry with end-of-bucket set and cam-continue clear ends the search with a miss.
- R7: If entry 3 is valid, does not match and has cam-continue clear, the result is a miss after exactly four table reads.
- R8: A valid, non-matching bucket entry with cam-continue set moves the search to CAM address {bank, cam pointer}. This takes precedence over end-of-bucket, and no further table reads follow.
- R9: The CAM is walked at ascending addresses. The search ends with a hit on a match, or with a miss on an invalid entry, an end-of-bucket entry, or the last CAM address. Cam-continue is ignored inside the CAM.
- R10: cfg_bank is sampled at acceptance and drives the bank bit of every read of that lookup in both memories. Changing it during the lookup has no effect.
- R11: rsp_valid, rsp_hit and rsp_entry stay stable until rsp_ready is 1. While a lookup or a response is pending, req_ready is 0. On a miss, rsp_entry is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank | input | BSEL_W | Active bank for new lookups |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Engine idle and able to accept |
| req_mac | input | 48 | Key MAC address |
| req_fid | input | 8 | Key FID |
| req_hash | input | HASH_W | Bucket number |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_addr | output | TBL_AW | Table read address |
| tbl_rd_data | input | ENTRY_W | Table data, one cycle after the strobe |
| cam_rd_en | output | 1 | CAM read strobe |
| cam_rd_addr | output | CAM_AW | CAM read address |
| cam_rd_data | input | ENTRY_W | CAM data, one cycle after the strobe |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 = match found |
| rsp_entry | output | ENTRY_W | Matched entry, zero on a miss |

## Verification
The bench counts table and CAM reads per lookup, so early stops are checked directly. An engine that ignored end-of-bucket, invalid entries or the bucket end would show extra reads. One that let end-of-bucket win over cam-continue would never touch the CAM. A key whose MAC matches but whose FID differs must be skipped, and an invalid entry carrying the exact key must miss. CAM walks are driven into the end-of-bucket stop, the last-address stop and an ignored cam-continue flag. The bank input is flipped in the middle of a lookup to catch an engine that reads it live.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
   localparam int MBL_MAC_W  = 48;
   localparam int MBL_FID_W  = 8;
   localparam int MBL_PORTS  = 16;
   localparam int MBL_PRIO_W = 3;
   localparam int MBL_PTR_W  = 5;

   typedef struct packed {
      logic                  valid;
      logic                  eob;
      logic                  bpdu;
      logic [MBL_MAC_W-1:0]  mac;
      logic [MBL_FID_W-1:0]  fid;
      logic [MBL_PORTS-1:0]  src_mask;
      logic [MBL_PORTS-1:0]  dst_mask;
      logic                  drop_on_src;
      logic                  drop_on_dst;
      logic                  drop_foreign_src;
      logic [MBL_PRIO_W-1:0] src_prio;
      logic                  src_prio_vld;
      logic                  src_prio_force;
      logic [MBL_PRIO_W-1:0] dst_prio;
      logic                  dst_prio_vld;
      logic                  dst_prio_force;
      logic                  cam_cont;
      logic [MBL_PTR_W-1:0]  cam_ptr;
   } mbl_entry_t;

   localparam int MBL_ENTRY_W = $bits(mbl_entry_t);

   typedef enum logic [1:0] {
      DEC_NEXT = 2'd0,
      DEC_HIT  = 2'd1,
      DEC_MISS = 2'd2,
      DEC_CAM  = 2'd3
   } mbl_dec_e;
endpackage

// File: rtl/mbl_entry_eval.sv
module mbl_entry_eval
   import mbl_pkg::*;
(
   input  logic                 ent_valid,
   input  logic                 ent_eob,
   input  logic                 ent_cam_cont,
   input  logic [MBL_MAC_W-1:0] ent_mac,
   input  logic [MBL_FID_W-1:0] ent_fid,
   input  logic [MBL_MAC_W-1:0] key_mac,
   input  logic [MBL_FID_W-1:0] key_fid,
   input  logic                 in_cam,
   input  logic                 at_last,
   output mbl_dec_e             dec
);
   logic key_eq;

   assign key_eq = (ent_mac == key_mac) && (ent_fid == key_fid);

   always_comb begin
      if (ent_valid && key_eq)            dec = DEC_HIT;
      else if (!ent_valid)                dec = DEC_MISS;
      else if (!in_cam && ent_cam_cont)   dec = DEC_CAM;
      else if (ent_eob || at_last)        dec = DEC_MISS;
      else                                dec = DEC_NEXT;
   end
endmodule

// File: rtl/mbl_rsp_hold.sv
module mbl_rsp_hold
   import mbl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       load_hit,
   input  mbl_entry_t load_ent,
   input  logic       rsp_ready,
   output logic       rsp_valid,
   output logic       rsp_hit,
   output mbl_entry_t rsp_ent
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_ent   <= '0;
      end else if (load) begin
         rsp_valid <= 1'b1;
         rsp_hit   <= load_hit;
         rsp_ent   <= load_hit ? load_ent : '0;
      end else if (rsp_valid && rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   // R11
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ent));

   // R11
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_ent == '0);
endmodule

// File: rtl/mac_bucket_lookup.sv
module mac_bucket_lookup
   import mbl_pkg::*;
#(
   parameter  int HASH_W    = 11,
   parameter  int BANKS     = 2,
   parameter  int CAM_DEPTH = 32,
   localparam int BANK_BITS = (BANKS > 1) ? $clog2(BANKS) : 0,
   localparam int BSEL_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int CAM_IW    = $clog2(CAM_DEPTH),
   localparam int TBL_AW    = BANK_BITS + HASH_W + 2,
   localparam int CAM_AW    = BANK_BITS + CAM_IW,
   localparam int ENTRY_W   = MBL_ENTRY_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BSEL_W-1:0]    cfg_bank,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [MBL_MAC_W-1:0] req_mac,
   input  logic [MBL_FID_W-1:0] req_fid,
   input  logic [HASH_W-1:0]    req_hash,
   output logic                 tbl_rd_en,
   output logic [TBL_AW-1:0]    tbl_rd_addr,
   input  logic [ENTRY_W-1:0]   tbl_rd_data,
   output logic                 cam_rd_en,
   output logic [CAM_AW-1:0]    cam_rd_addr,
   input  logic [ENTRY_W-1:0]   cam_rd_data,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic                 rsp_hit,
   output logic [ENTRY_W-1:0]   rsp_entry
);
   initial begin
      assert (HASH_W >= 1) else $error("HASH_W must be at least 1");
      assert (BANKS >= 1 && (BANKS & (BANKS - 1)) == 0) else $error("BANKS must be a power of two");
      assert (CAM_DEPTH >= 2 && (CAM_DEPTH & (CAM_DEPTH - 1)) == 0) else $error("CAM_DEPTH must be a power of two");
      assert (CAM_IW <= MBL_PTR_W) else $error("CAM_DEPTH exceeds the entry pointer range");
   end

   typedef enum logic [1:0] {S_IDLE, S_TBL, S_CAM, S_RSP} state_e;

   state_e                state;
   logic [MBL_MAC_W-1:0]  key_mac;
   logic [MBL_FID_W-1:0]  key_fid;
   logic [HASH_W-1:0]     hash_q;
   logic [BSEL_W-1:0]     bank_q;
   logic [1:0]            idx_q;
   logic [CAM_IW-1:0]     cam_q;

   mbl_entry_t            tbl_ent, cam_ent, cur_ent, rsp_ent_s;
   mbl_dec_e              dec;
   logic                  req_fire, searching, at_last, finish;
   logic [1:0]            idx_nxt;
   logic [CAM_IW-1:0]     cam_nxt, cam_start;

   assign tbl_ent   = mbl_entry_t'(tbl_rd_data);
   assign cam_ent   = mbl_entry_t'(cam_rd_data);
   assign cur_ent   = (state == S_CAM) ? cam_ent : tbl_ent;
   assign req_ready = (state == S_IDLE);
   assign req_fire  = req_valid && req_ready;
   assign searching = (state == S_TBL) || (state == S_CAM);
   assign at_last   = (state == S_CAM) ? (cam_q == CAM_IW'(CAM_DEPTH - 1)) : (idx_q == 2'd3);
   assign finish    = searching && ((dec == DEC_HIT) || (dec == DEC_MISS));
   assign idx_nxt   = idx_q + 2'd1;
   assign cam_nxt   = cam_q + CAM_IW'(1);
   assign cam_start = tbl_ent.cam_ptr[CAM_IW-1:0];

   mbl_entry_eval u_eval (
      .ent_valid    (cur_ent.valid),
      .ent_eob      (cur_ent.eob),
      .ent_cam_cont (cur_ent.cam_cont),
      .ent_mac      (cur_ent.mac),
      .ent_fid      (cur_ent.fid),
      .key_mac      (key_mac),
      .key_fid      (key_fid),
      .in_cam       (state == S_CAM),
      .at_last      (at_last),
      .dec          (dec)
   );

   assign tbl_rd_en = req_fire || ((state == S_TBL) && (dec == DEC_NEXT));
   assign cam_rd_en = ((state == S_TBL) && (dec == DEC_CAM)) ||
                      ((state == S_CAM) && (dec == DEC_NEXT));

   generate
      if (BANK_BITS > 0) begin : g_banked
         assign tbl_rd_addr = req_fire ? {cfg_bank, req_hash, 2'b00} : {bank_q, hash_q, idx_nxt};
         assign cam_rd_addr = (state == S_TBL) ? {bank_q, cam_start} : {bank_q, cam_nxt};
      end else begin : g_flat
         assign tbl_rd_addr = req_fire ? {req_hash, 2'b00} : {hash_q, idx_nxt};
         assign cam_rd_addr = (state == S_TBL) ? cam_start : cam_nxt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         key_mac <= '0;
         key_fid <= '0;
         hash_q  <= '0;
         bank_q  <= '0;
         idx_q   <= '0;
         cam_q   <= '0;
      end else begin
         case (state)
            S_IDLE: if (req_fire) begin
               key_mac <= req_mac;
               key_fid <= req_fid;
               hash_q  <= req_hash;
               bank_q  <= cfg_bank;
               idx_q   <= 2'd0;
               state   <= S_TBL;
            end
            S_TBL: begin
               if (dec == DEC_NEXT) idx_q <= idx_nxt;
               else if (dec == DEC_CAM) begin
                  cam_q <= cam_start;
                  state <= S_CAM;
               end else state <= S_RSP;
            end
            S_CAM: begin
               if (dec == DEC_NEXT) cam_q <= cam_nxt;
               else state <= S_RSP;
            end
            default: if (rsp_valid && rsp_ready) state <= S_IDLE;
         endcase
      end
   end

   mbl_rsp_hold u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (finish),
      .load_hit  (dec == DEC_HIT),
      .load_ent  (cur_ent),
      .rsp_ready (rsp_ready),
      .rsp_valid (rsp_valid),
      .rsp_hit   (rsp_hit),
      .rsp_ent   (rsp_ent_s)
   );

   assign rsp_entry = rsp_ent_s;

   // R11
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R10
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != S_IDLE |=> $stable(bank_q));

   // R3
   hit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> rsp_ent_s.valid && rsp_ent_s.mac == key_mac && rsp_ent_s.fid == key_fid);

   // R8
   cam_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cam_rd_en |=> !tbl_rd_en);
endmodule

// File: tb/test_mac_bucket_lookup.sv
`timescale 1ns/1ps
module test_mac_bucket_lookup;
   import mbl_pkg::*;

   localparam int HW = 4;
   localparam int CD = 8;
   localparam int TAW = 1 + HW + 2;
   localparam int CAW = 1 + 3;
   localparam int EW = MBL_ENTRY_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [0:0] cfg_bank = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [47:0] req_mac = '0;
   logic [7:0] req_fid = '0;
   logic [HW-1:0] req_hash = '0;
   logic tbl_rd_en, cam_rd_en;
   logic [TAW-1:0] tbl_rd_addr;
   logic [CAW-1:0] cam_rd_addr;
   logic [EW-1:0] tbl_q, cam_q;
   logic rsp_valid, rsp_hit;
   logic rsp_ready = 1'b0;
   logic [EW-1:0] rsp_entry;

   always #2.5 clk = ~clk;

   mac_bucket_lookup #(.HASH_W(HW), .BANKS(2), .CAM_DEPTH(CD)) i_mac_bucket_lookup (
      .clk(clk), .rst_n(rst_n), .cfg_bank(cfg_bank),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_mac(req_mac), .req_fid(req_fid), .req_hash(req_hash),
      .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_q),
      .cam_rd_en(cam_rd_en), .cam_rd_addr(cam_rd_addr), .cam_rd_data(cam_q),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_entry(rsp_entry)
   );

   mbl_entry_t tbl_mem [0:(1<<TAW)-1];
   mbl_entry_t cam_mem [0:(1<<CAW)-1];

   int checks = 0;
   int errors = 0;
   int n_tbl = 0, n_cam = 0, bad_bank = 0;
   logic [TAW-1:0] first_tbl;
   logic [CAW-1:0] first_cam;
   logic exp_bank = 1'b0;
   bit finished = 0;

   always @(posedge clk) begin
      if (tbl_rd_en) begin
         tbl_q <= tbl_mem[tbl_rd_addr];
         if (n_tbl == 0) first_tbl = tbl_rd_addr;
         if (tbl_rd_addr[TAW-1] != exp_bank) bad_bank++;
         n_tbl++;
      end
      if (cam_rd_en) begin
         cam_q <= cam_mem[cam_rd_addr];
         if (n_cam == 0) first_cam = cam_rd_addr;
         if (cam_rd_addr[CAW-1] != exp_bank) bad_bank++;
         n_cam++;
      end
   end

   localparam logic [47:0] KMAC = 48'h0200_1234_5678;
   localparam logic [7:0]  KFID = 8'h21;
   localparam logic [47:0] OMAC = 48'h0200_9999_0001;

   function automatic mbl_entry_t mk(logic v, logic eob, logic go, logic [4:0] ptr,
                                     logic [47:0] mac, logic [7:0] fid, logic [15:0] tag);
      mbl_entry_t e;
      e = '0;
      e.valid = v; e.eob = eob; e.cam_cont = go; e.cam_ptr = ptr;
      e.mac = mac; e.fid = fid; e.dst_mask = tag; e.src_mask = ~tag;
      e.bpdu = tag[0]; e.src_prio = tag[3:1]; e.dst_prio = tag[6:4];
      e.drop_on_dst = tag[7];
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Runs one lookup and checks result, read counts and response hold.
   task automatic lookup(input string req, input logic [HW-1:0] h, input logic bank,
                         input logic flip, input logic [7:0] fid,
                         input logic exp_hit, input mbl_entry_t exp_ent,
                         input int exp_tbl, input int exp_cam);
      int wait_n;
      logic [EW-1:0] held;
      @(negedge clk);
      n_tbl = 0; n_cam = 0; bad_bank = 0; exp_bank = bank;
      cfg_bank = bank; req_mac = KMAC; req_fid = fid; req_hash = h; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) cfg_bank = ~bank;
      wait_n = 0;
      while (!rsp_valid && wait_n < 50) begin
         @(negedge clk);
         wait_n++;
      end
      chk(rsp_valid, req, "response arrives", 64'(rsp_valid), 64'd1);
      chk(rsp_hit == exp_hit, req, "hit flag", 64'(rsp_hit), 64'(exp_hit));
      chk(rsp_entry == (exp_hit ? EW'(exp_ent) : '0), req, "entry", rsp_entry[63:0],
          exp_hit ? 64'(exp_ent) : 64'd0);
      chk(n_tbl == exp_tbl, req, "table reads", 64'(n_tbl), 64'(exp_tbl));
      chk(n_cam == exp_cam, req, "cam reads", 64'(n_cam), 64'(exp_cam));
      chk(bad_bank == 0, req, "reads outside bank", 64'(bad_bank), 64'd0);
      held = rsp_entry;
      repeat (2) @(negedge clk);
      // R11 response held, no new request accepted
      chk(rsp_valid && rsp_entry == held && req_ready == 1'b0, "R11", "hold under backpressure",
          {62'd0, rsp_valid, req_ready}, 64'd2);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R11", "release after accept", {62'd0, rsp_valid, req_ready}, 64'd1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      // R1
      chk(req_ready && !rsp_valid && !tbl_rd_en && !cam_rd_en, "R1", "reset state",
          {60'd0, req_ready, rsp_valid, tbl_rd_en, cam_rd_en}, 64'h8);
   endtask

   task automatic t_hit_first();
      mbl_entry_t e = mk(1, 0, 0, 0, KMAC, KFID, 16'h00A1);
      tbl_mem[{1'b0, 4'd1, 2'd0}] = e;
      lookup("R3", 4'd1, 1'b0, 1'b0, KFID, 1'b1, e, 1, 0);
      // R2 first read at {bank, hash, 00}
      chk(first_tbl == 7'd4, "R2", "first table address", 64'(first_tbl), 64'd4);
   endtask

   task automatic t_hit_third();
      mbl_entry_t e = mk(1, 0, 0, 0, KMAC, KFID, 16'h0033);
      tbl_mem[{1'b0, 4'd2, 2'd0}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h1);
      tbl_mem[{1'b0, 4'd2, 2'd1}] = mk(1, 0, 0, 0, KMAC, 8'h22, 16'h2);
      tbl_mem[{1'b0, 4'd2, 2'd2}] = e;
      tbl_mem[{1'b0, 4'd2, 2'd3}] = mk(1, 0, 0, 0, KMAC, KFID, 16'h4);
      lookup("R4", 4'd2, 1'b0, 1'b0, KFID, 1'b1, e, 3, 0);
   endtask

   task automatic t_invalid_stop();
      tbl_mem[{1'b0, 4'd3, 2'd0}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h1);
      tbl_mem[{1'b0, 4'd3, 2'd2}] = mk(1, 0, 0, 0, KMAC, KFID, 16'h3);
      lookup("R5", 4'd3, 1'b0, 1'b0, KFID, 1'b0, '0, 2, 0);
   endtask

   task automatic t_eob_stop();
      tbl_mem[{1'b0, 4'd4, 2'd0}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h1);
      tbl_mem[{1'b0, 4'd4, 2'd1}] = mk(1, 1, 0, 0, OMAC, KFID, 16'h2);
      tbl_mem[{1'b0, 4'd4, 2'd2}] = mk(1, 0, 0, 0, KMAC, KFID, 16'h3);
      lookup("R6", 4'd4, 1'b0, 1'b0, KFID, 1'b0, '0, 2, 0);
   endtask

   task automatic t_full_bucket();
      for (int i = 0; i < 4; i++)
         tbl_mem[{1'b0, 4'd5, 2'(i)}] = mk(1, 0, 0, 0, OMAC + 48'(i), KFID, 16'(i));
      lookup("R7", 4'd5, 1'b0, 1'b0, KFID, 1'b0, '0, 4, 0);
   endtask

   task automatic t_cam_hit();
      mbl_entry_t e = mk(1, 0, 0, 0, KMAC, KFID, 16'h0077);
      tbl_mem[{1'b0, 4'd6, 2'd0}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h1);
      tbl_mem[{1'b0, 4'd6, 2'd1}] = mk(1, 1, 1, 5'd3, OMAC, KFID, 16'h2);
      cam_mem[{1'b0, 3'd3}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h5);
      cam_mem[{1'b0, 3'd4}] = e;
      lookup("R8", 4'd6, 1'b0, 1'b0, KFID, 1'b1, e, 2, 2);
      chk(first_cam == 4'd3, "R8", "first cam address", 64'(first_cam), 64'd3);
   endtask

   task automatic t_cam_eob();
      tbl_mem[{1'b0, 4'd7, 2'd0}] = mk(1, 0, 1, 5'd0, OMAC, KFID, 16'h1);
      cam_mem[{1'b0, 3'd0}] = mk(1, 0, 1, 5'd6, OMAC, KFID, 16'h2);
      cam_mem[{1'b0, 3'd1}] = mk(1, 1, 0, 0, OMAC, KFID, 16'h3);
      cam_mem[{1'b0, 3'd2}] = mk(1, 0, 0, 0, KMAC, KFID, 16'h4);
      lookup("R9", 4'd7, 1'b0, 1'b0, KFID, 1'b0, '0, 1, 2);
      chk(first_cam == 4'd0, "R9", "cam start", 64'(first_cam), 64'd0);
   endtask

   task automatic t_cam_last();
      tbl_mem[{1'b0, 4'd8, 2'd0}] = mk(1, 0, 1, 5'd6, OMAC, KFID, 16'h1);
      cam_mem[{1'b0, 3'd6}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h6);
      cam_mem[{1'b0, 3'd7}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h7);
      lookup("R9", 4'd8, 1'b0, 1'b0, KFID, 1'b0, '0, 1, 2);
   endtask

   task automatic t_bank();
      mbl_entry_t e1 = mk(1, 0, 0, 0, KMAC, KFID, 16'h0091);
      mbl_entry_t e2 = mk(1, 0, 0, 0, KMAC, KFID, 16'h00B2);
      tbl_mem[{1'b0, 4'd9, 2'd0}] = mk(1, 0, 0, 0, KMAC, KFID, 16'h10);
      tbl_mem[{1'b1, 4'd9, 2'd0}] = mk(1, 0, 0, 0, OMAC, KFID, 16'h11);
      tbl_mem[{1'b1, 4'd9, 2'd1}] = e1;
      lookup("R10", 4'd9, 1'b1, 1'b1, KFID, 1'b1, e1, 2, 0);
      tbl_mem[{1'b1, 4'd11, 2'd0}] = mk(1, 0, 1, 5'd2, OMAC, KFID, 16'h12);
      cam_mem[{1'b1, 3'd2}] = e2;
      lookup("R10", 4'd11, 1'b1, 1'b1, KFID, 1'b1, e2, 1, 1);
      chk(first_cam == 4'd10, "R10", "cam bank address", 64'(first_cam), 64'd10);
   endtask

   task automatic t_invalid_key();
      tbl_mem[{1'b0, 4'd10, 2'd0}] = mk(0, 0, 0, 0, KMAC, KFID, 16'h1);
      lookup("R3", 4'd10, 1'b0, 1'b0, KFID, 1'b0, '0, 1, 0);
   endtask

   initial begin
      for (int i = 0; i < (1 << TAW); i++) tbl_mem[i] = '0;
      for (int i = 0; i < (1 << CAW); i++) cam_mem[i] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_first();
      t_hit_third();
      t_invalid_stop();
      t_eob_stop();
      t_full_bucket();
      t_cam_hit();
      t_cam_eob();
      t_cam_last();
      t_bank();
      t_invalid_key();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule